// File: doc/BRIEF.md
# Synchronous Buck Switching Sequencer

This block is the cycle-level control logic of a current-mode synchronous step-down converter. Once per switching period it starts a new cycle. After a programmable dead time it enables the high-side switch. It turns that switch off on a comparator trip, on the current limit, or when the on-time reaches its duty ceiling. After a second dead time it enables the low-side rectifier, which stays on until the cycle ends or a current comparator releases it. The analog comparators are outside the block. Each one arrives here as a single digital flag that is already aligned to the system clock.

The switching period comes from an internal counter. A frequency-select input chooses between a slow setting and a fast setting. A falling edge on the sync pin starts a new cycle and locks the timer to the external clock. If the external clock stops, the block returns to its own period. A mode input selects one of two light-load behaviours:

- **Forced-continuous:** every cycle produces a pulse, and the inductor current may reverse down to a negative limit.
- **Pulse-skipping:** every pulse is held until a minimum-current floor is reached, the rectifier opens at zero current, and cycles are dropped when the output needs no energy.

Top module: `buck_cycle_seq`

## Requirements
- R1: While rst_ni is low, hs_en_o, ls_en_o and cycle_start_o are all low.
- R2: With no sync input, cycle_start_o pulses for one cycle every PER_LO clocks when freq_sel_i is 0, and every PER_HI clocks when freq_sel_i is 1.
- R3: hs_en_o rises DEAD+1 clocks after a cycle_start_o pulse. It falls in the clock after a terminating flag is seen: cur_lim_i in either mode, pwm_trip_i in continuous mode.
- R4: hs_en_o is never high for more than P - P/16 consecutive clocks, where P is the selected period. Without a terminating flag it stays high exactly that long.
- R5: hs_en_o and ls_en_o are never high together. Each one rises only after the other has been low for at least DEAD clocks. When the high side turns off, ls_en_o rises after exactly DEAD clocks.
- R6: With cont_mode_i = 1, the low side turns off only when the next cycle starts or when cur_rev_i is asserted. In this mode cur_zero_i and cur_floor_i have no effect, and every cycle start produces a high-side pulse, even when pwm_trip_i is held high.
- R7: With cont_mode_i = 0, pwm_trip_i ends the on-time only together with cur_floor_i, while cur_lim_i still ends it alone. The low side turns off in the clock after cur_zero_i is asserted, and cur_rev_i has no effect.
- R8: With cont_mode_i = 0, a cycle start that finds pwm_trip_i high skips that cycle. Neither gate is enabled until a later start.
- R9: A falling edge on sync_i, as sampled on the clock, produces a cycle_start_o pulse 3 clocks later and restarts the period count. While locked, the internal period produces no cycle starts.
- R10: When locked, if no further sync fall arrives within P + P/2 clocks of the last start, a cycle start is issued at that point. The internal period of P clocks then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_sel_i | input | 1 | Internal period select: 0 = PER_LO, 1 = PER_HI |
| cont_mode_i | input | 1 | 1 = forced-continuous, 0 = pulse-skipping |
| sync_i | input | 1 | External sync clock, asynchronous; the falling edge starts a cycle |
| pwm_trip_i | input | 1 | Main PWM comparator tripped |
| cur_lim_i | input | 1 | Peak current limit reached |
| cur_floor_i | input | 1 | Inductor current has reached the minimum-current floor |
| cur_zero_i | input | 1 | Inductor current has fallen to zero |
| cur_rev_i | input | 1 | Inductor current has reached the negative limit |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| cycle_start_o | output | 1 | One-clock pulse at each cycle start |

## Verification
The assertions check on every cycle the properties that hold at all times:

- the two gates never overlap, and each rises only after the dead-time gap;
- the high-side run never exceeds the duty ceiling;
- the low side always drops after a cycle start;
- the sync-to-start latency is fixed.

Other behaviours depend on a chosen scenario, and only the bench's stimulus can show them:

- the period lengths;
- the exact pulse widths under each comparator combination;
- the differences between the two modes;
- cycle skipping;
- suppression of internal starts while locked, and the fallback timeout.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [2:0] {
    GS_IDLE,
    GS_GAP_HI,
    GS_HIGH,
    GS_GAP_LO,
    GS_LOW
  } gate_st_e;
endpackage

// File: rtl/buck_sync_edge.sv
module buck_sync_edge #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic fall_o
);
  logic [DEPTH:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[DEPTH-1:0], sync_i};
  end

  assign fall_o = sh_q[DEPTH] & ~sh_q[DEPTH-1];
endmodule

// File: rtl/buck_osc_timer.sv
module buck_osc_timer #(
  parameter int unsigned PER_LO = 1250,
  parameter int unsigned PER_HI = 833,
  parameter int unsigned CNT_W  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freq_sel_i,
  input  logic sync_fall_i,
  output logic start_o
);
  logic [CNT_W-1:0] cnt_q, per, lock_lim;
  logic             locked_q, start_q;
  logic             tick, timeout, fire;

  assign per      = freq_sel_i ? CNT_W'(PER_HI) : CNT_W'(PER_LO);
  assign lock_lim = per + (per >> 1);
  assign tick     = !locked_q && (cnt_q >= per - 1'b1);
  assign timeout  = locked_q && (cnt_q >= lock_lim - 1'b1);
  assign fire     = sync_fall_i | tick | timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      cnt_q   <= fire ? '0 : cnt_q + 1'b1;
      start_q <= fire;
      if (sync_fall_i)  locked_q <= 1'b1;
      else if (timeout) locked_q <= 1'b0;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/buck_gate_fsm.sv
module buck_gate_fsm
  import buck_seq_pkg::*;
#(
  parameter int unsigned DEAD = 15,
  parameter int unsigned ON_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cont_mode_i,
  input  logic            pwm_trip_i,
  input  logic            cur_lim_i,
  input  logic            cur_floor_i,
  input  logic            cur_zero_i,
  input  logic            cur_rev_i,
  input  logic [ON_W-1:0] max_on_i,
  output logic            hs_en_o,
  output logic            ls_en_o
);
  localparam int unsigned DT_W = (DEAD > 1) ? $clog2(DEAD) : 1;

  gate_st_e        st_q, st_d;
  logic [DT_W-1:0] dt_q, dt_d;
  logic [ON_W-1:0] on_q, on_d;
  logic            hs_stop, ls_stop, skip_now, dt_done;

  assign hs_stop  = cur_lim_i | (pwm_trip_i & (cont_mode_i | cur_floor_i))
                  | (on_q >= max_on_i - 1'b1);
  assign ls_stop  = cont_mode_i ? cur_rev_i : cur_zero_i;
  assign skip_now = start_i & ~cont_mode_i & pwm_trip_i;
  assign dt_done  = (dt_q == DT_W'(DEAD - 1));

  always_comb begin
    st_d = st_q;
    dt_d = dt_q;
    on_d = on_q;
    case (st_q)
      GS_HIGH: begin
        // starts during the on-time are dropped
        if (hs_stop) begin
          st_d = GS_GAP_LO;
          dt_d = '0;
        end else begin
          on_d = on_q + 1'b1;
        end
      end
      GS_GAP_LO: begin
        if (skip_now)     st_d = GS_IDLE;
        else if (start_i) begin
          st_d = GS_GAP_HI;
          dt_d = '0;
        end else if (dt_done) st_d = GS_LOW;
        else                  dt_d = dt_q + 1'b1;
      end
      GS_LOW: begin
        if (skip_now)     st_d = GS_IDLE;
        else if (start_i) begin
          st_d = GS_GAP_HI;
          dt_d = '0;
        end else if (ls_stop) st_d = GS_IDLE;
      end
      GS_GAP_HI: begin
        if (skip_now)     st_d = GS_IDLE;
        else if (dt_done) begin
          st_d = GS_HIGH;
          on_d = '0;
        end else dt_d = dt_q + 1'b1;
      end
      default: begin
        if (start_i && !skip_now) begin
          st_d = GS_GAP_HI;
          dt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= GS_IDLE;
      dt_q <= '0;
      on_q <= '0;
    end else begin
      st_q <= st_d;
      dt_q <= dt_d;
      on_q <= on_d;
    end
  end

  assign hs_en_o = (st_q == GS_HIGH);
  assign ls_en_o = (st_q == GS_LOW);
endmodule

// File: rtl/buck_cycle_seq.sv
module buck_cycle_seq
  import buck_seq_pkg::*;
#(
  parameter int unsigned PER_LO = 1250,
  parameter int unsigned PER_HI = 833,
  parameter int unsigned DEAD   = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freq_sel_i,
  input  logic cont_mode_i,
  input  logic sync_i,
  input  logic pwm_trip_i,
  input  logic cur_lim_i,
  input  logic cur_floor_i,
  input  logic cur_zero_i,
  input  logic cur_rev_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic cycle_start_o
);
  localparam int unsigned PER_MAX    = (PER_LO > PER_HI) ? PER_LO : PER_HI;
  localparam int unsigned CNT_W      = $clog2(PER_MAX + PER_MAX / 2 + 1);
  localparam int unsigned MAX_ON_LO  = PER_LO - PER_LO / 16;
  localparam int unsigned MAX_ON_HI  = PER_HI - PER_HI / 16;
  localparam int unsigned MAX_ON_CAP = (MAX_ON_LO > MAX_ON_HI) ? MAX_ON_LO : MAX_ON_HI;
  localparam int unsigned ON_W       = $clog2(MAX_ON_CAP + 1);

  logic            sync_fall, start;
  logic [ON_W-1:0] max_on;

  assign max_on = freq_sel_i ? ON_W'(MAX_ON_HI) : ON_W'(MAX_ON_LO);

  buck_sync_edge #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .fall_o (sync_fall)
  );

  buck_osc_timer #(.PER_LO(PER_LO), .PER_HI(PER_HI), .CNT_W(CNT_W)) u_osc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .freq_sel_i  (freq_sel_i),
    .sync_fall_i (sync_fall),
    .start_o     (start)
  );

  buck_gate_fsm #(.DEAD(DEAD), .ON_W(ON_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cont_mode_i (cont_mode_i),
    .pwm_trip_i  (pwm_trip_i),
    .cur_lim_i   (cur_lim_i),
    .cur_floor_i (cur_floor_i),
    .cur_zero_i  (cur_zero_i),
    .cur_rev_i   (cur_rev_i),
    .max_on_i    (max_on),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o)
  );

  assign cycle_start_o = start;
endmodule

// File: rtl/buck_cycle_seq_chk.sv
module buck_cycle_seq_chk #(
  parameter int unsigned DEAD   = 15,
  parameter int unsigned MAX_ON = 1172
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic cycle_start_o
);
  localparam int unsigned DW = $clog2(DEAD + 1);
  localparam int unsigned RW = $clog2(MAX_ON + 2);

  logic [DW-1:0] hs_gap_q, ls_gap_q;
  logic [RW-1:0] run_q;
  logic [3:0]    since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_gap_q <= DW'(DEAD);
      ls_gap_q <= DW'(DEAD);
      run_q    <= '0;
      since_q  <= '0;
    end else begin
      hs_gap_q <= hs_en_o ? '0 : ((hs_gap_q < DW'(DEAD)) ? hs_gap_q + 1'b1 : hs_gap_q);
      ls_gap_q <= ls_en_o ? '0 : ((ls_gap_q < DW'(DEAD)) ? ls_gap_q + 1'b1 : ls_gap_q);
      run_q    <= hs_en_o ? run_q + 1'b1 : '0;
      since_q  <= (since_q < 4'd8) ? since_q + 1'b1 : since_q;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!hs_en_o && !ls_en_o && !cycle_start_o));

  // R5
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  // R5
  ls_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> (hs_gap_q >= DW'(DEAD)));

  // R5
  hs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> (ls_gap_q >= DW'(DEAD)));

  // R4
  max_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> (run_q < RW'(MAX_ON)));

  // R6
  ls_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_en_o && cycle_start_o) |=> !ls_en_o);

  // R9
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 4'd4 && $past(sync_i, 4) && !$past(sync_i, 3)) |-> cycle_start_o);
endmodule

bind buck_cycle_seq buck_cycle_seq_chk #(.DEAD(DEAD), .MAX_ON(MAX_ON_CAP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sync_i        (sync_i),
  .hs_en_o       (hs_en_o),
  .ls_en_o       (ls_en_o),
  .cycle_start_o (cycle_start_o)
);

// File: tb/buck_cycle_seq_test.sv
module buck_cycle_seq_test;
  localparam int PLO = 240;
  localparam int PHI = 160;
  localparam int DT  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic freq_sel_i = 1'b0, cont_mode_i = 1'b1, sync_i = 1'b1;
  logic pwm_trip_i = 1'b0, cur_lim_i = 1'b0, cur_floor_i = 1'b0;
  logic cur_zero_i = 1'b0, cur_rev_i = 1'b0;
  logic hs_en_o, ls_en_o, cycle_start_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  buck_cycle_seq #(.PER_LO(PLO), .PER_HI(PHI), .DEAD(DT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .freq_sel_i(freq_sel_i), .cont_mode_i(cont_mode_i),
    .sync_i(sync_i), .pwm_trip_i(pwm_trip_i), .cur_lim_i(cur_lim_i),
    .cur_floor_i(cur_floor_i), .cur_zero_i(cur_zero_i), .cur_rev_i(cur_rev_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .cycle_start_o(cycle_start_o)
  );

  function automatic int per_of(input logic fs);
    return fs ? PHI : PLO;
  endfunction

  function automatic int max_on_of(input logic fs);
    return per_of(fs) - per_of(fs) / 16;
  endfunction

  function automatic int exp_width(input logic cont, input int kind, input int k, input int m, input logic fs);
    if (kind == 1) return k;
    if (cont) return k;
    if (kind == 2) return k + m;
    return max_on_of(fs);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!cycle_start_o);
  endtask

  task automatic measure_period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!cycle_start_o);
  endtask

  task automatic wait_hs_rise();
    while (hs_en_o) @(negedge clk);
    while (!hs_en_o) @(negedge clk);
  endtask

  task automatic pulse_trial(input logic cont, input int kind, input int k, input int m, output int w);
    cont_mode_i = cont;
    wait_start();
    wait_hs_rise();
    w = 0;
    while (hs_en_o) begin
      w++;
      if (w == k) begin
        if (kind == 1) cur_lim_i = 1'b1;
        else           pwm_trip_i = 1'b1;
      end
      if (kind == 2 && w == k + m) cur_floor_i = 1'b1;
      @(negedge clk);
    end
    pwm_trip_i = 1'b0;
    cur_lim_i = 1'b0;
    cur_floor_i = 1'b0;
  endtask

  task automatic ls_trial(input logic cont, input int j, output int w);
    cont_mode_i = cont;
    wait_start();
    wait_hs_rise();
    w = 0;
    while (hs_en_o) begin
      w++;
      if (w == 10) cur_lim_i = 1'b1;
      @(negedge clk);
    end
    cur_lim_i = 1'b0;
    while (!ls_en_o) @(negedge clk);
    w = 0;
    while (ls_en_o) begin
      w++;
      if (w == 1) begin
        if (cont) cur_zero_i = 1'b1;
        else      cur_rev_i = 1'b1;
      end
      if (w == j) begin
        if (cont) cur_rev_i = 1'b1;
        else      cur_zero_i = 1'b1;
      end
      @(negedge clk);
    end
    cur_zero_i = 1'b0;
    cur_rev_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, w, hs_cnt, ls_cnt, starts, seed;
    seed = $urandom(32'd4242);

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 hs", int'(hs_en_o), 0);
    check("R1 ls", int'(ls_en_o), 0);
    check("R1 start", int'(cycle_start_o), 0);
    rst_ni = 1'b1;

    // R2 internal periods
    wait_start();
    measure_period(n);
    check("R2 slow period", n, PLO);
    freq_sel_i = 1'b1;
    wait_start();
    measure_period(n);
    check("R2 fast period", n, PHI);

    // R3 R4 R5 R6 free-running continuous sequence, floor and zero flags ignored
    cur_zero_i = 1'b1;
    cur_floor_i = 1'b1;
    for (int f = 0; f < 2; f++) begin
      freq_sel_i = f[0];
      wait_start();
      wait_start();
      n = 0;
      while (!hs_en_o) begin @(negedge clk); n++; end
      check("R3 start to high side", n, DT + 1);
      w = 0;
      while (hs_en_o) begin w++; @(negedge clk); end
      check("R4 duty ceiling", w, max_on_of(f[0]));
      n = 0;
      while (!ls_en_o) begin n++; @(negedge clk); end
      check("R5 dead after high", n, DT);
      w = 0;
      while (ls_en_o) begin w++; @(negedge clk); end
      check("R6 low side until start", w, per_of(f[0]) - max_on_of(f[0]) - 2 * DT);
      n = 0;
      while (!hs_en_o) begin n++; @(negedge clk); end
      check("R5 dead before high", n, DT);
    end
    cur_zero_i = 1'b0;
    cur_floor_i = 1'b0;

    // R3 R7 random terminations in both modes
    for (int i = 0; i < 24; i++) begin
      logic fs, cont;
      int kind, k, m;
      fs = 1'($urandom % 2);
      cont = 1'($urandom % 2);
      kind = int'($urandom % 3);
      k = 1 + int'($urandom % (max_on_of(fs) - 20));
      m = 1 + int'($urandom % 10);
      freq_sel_i = fs;
      wait_start();
      pulse_trial(cont, kind, k, m, w);
      check(cont ? "R3 continuous on-time" : "R7 skip-mode on-time", w, exp_width(cont, kind, k, m, fs));
    end
    // directed corners: single-clock pulse and floor never reached
    freq_sel_i = 1'b0;
    pulse_trial(1'b1, 0, 1, 1, w);
    check("R3 one-clock pulse", w, 1);
    pulse_trial(1'b0, 0, 5, 1, w);
    check("R7 floor never reached", w, max_on_of(1'b0));

    // R6 R7 low-side release
    freq_sel_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      int j;
      j = 2 + int'($urandom % 50);
      ls_trial(1'b0, j, w);
      check("R7 zero-cross release", w, j);
      ls_trial(1'b1, j, w);
      check("R6 reverse-limit release", w, j);
    end

    // R8 skipped cycles
    cont_mode_i = 1'b0;
    pwm_trip_i = 1'b1;
    wait_start();
    wait_start();
    hs_cnt = 0;
    ls_cnt = 0;
    repeat (PHI) begin
      @(negedge clk);
      hs_cnt += int'(hs_en_o);
      ls_cnt += int'(ls_en_o);
    end
    check("R8 skip no high", hs_cnt, 0);
    check("R8 skip no low", ls_cnt, 0);
    // R6 trip held in continuous mode still gives one clock per cycle
    cont_mode_i = 1'b1;
    wait_start();
    wait_start();
    hs_cnt = 0;
    repeat (PHI) begin
      @(negedge clk);
      hs_cnt += int'(hs_en_o);
    end
    check("R6 pulse every cycle", hs_cnt, 1);
    pwm_trip_i = 1'b0;

    // R9 R10 external sync
    wait_start();
    repeat (20) @(negedge clk);
    sync_i = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!cycle_start_o && n < 10);
    check("R9 sync latency", n, 3);
    for (int r = 0; r < 2; r++) begin
      sync_i = 1'b1;
      starts = 0;
      repeat (197) begin
        @(negedge clk);
        starts += int'(cycle_start_o);
      end
      check("R9 internal starts suppressed", starts, 0);
      sync_i = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!cycle_start_o && n < 10);
      check("R9 locked period", n, 3);
    end
    sync_i = 1'b1;
    measure_period(n);
    check("R10 fallback timeout", n, PHI + PHI / 2);
    measure_period(n);
    check("R10 internal resumes", n, PHI);

    finish_run();
  end
endmodule